// File: doc/BRIEF.md
# Stretched External Data Memory Access Controller

This block carries out one single-byte read or write at a time to an external data memory that sits on a plain, non-multiplexed bus. It has a separate 24-bit address bus, an outgoing data bus, an incoming data bus, a read strobe, a write strobe, and an enable that tells the pad logic when to drive the outgoing data lines. The timing of the bus suits both fast and slow memories. A programmable stretch value keeps each strobe asserted for one to eight clock periods.

The address of every access comes from three pointer registers. The page byte supplies the top eight address bits, so rewriting only that byte moves the access to another 64 KB segment. A small configuration write port loads the pointer registers and the stretch register. The core starts an access by raising a request with a direction bit and, for a write, the data byte. The block latches everything it needs at acceptance. It runs a setup cycle, then the strobe, then a hold cycle. On the hold cycle it pulses `done`, and for a read it returns the captured byte at the same time.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `xm_rd`, `xm_wr`, `xm_drive`, `busy` and `done` are all low.
- R2: The bus address of an access equals {page, high, low}, taken from the pointer registers when the request is accepted. The `cfg_sel` codes are 0 = low byte (address bits 7:0), 1 = high byte (bits 15:8) and 2 = page byte (bits 23:16).
- R3: With `cfg_sel` code 3, bits 2:0 of `cfg_wdata` set the stretch value N, and the upper bits are ignored. The read or write strobe then stays high for exactly N+1 consecutive cycles, for every N from 0 to 7.
- R4: A request accepted at clock edge k gives a setup cycle, so the strobe first goes high in the second cycle after edge k. `xm_addr` and, for a write, `xm_wdata` hold their value from the setup cycle through the hold cycle that follows the strobe.
- R5: A read samples `xm_rdata` on the final cycle of the strobe. On the next cycle `done` is high for exactly one cycle and `rd_data` shows the sampled byte. `rd_data` keeps that byte until the next read completes.
- R6: `busy` is high from the cycle after acceptance through the `done` cycle, and is low on the cycle after `done`. A request that arrives while `busy` is high is ignored and starts no access.
- R7: `xm_drive` is high on every busy cycle of a write and is never high during a read or while idle.
- R8: `xm_rd` and `xm_wr` are never high together, and only the strobe that matches the request direction ever rises.
- R9: Writes to the pointer or stretch registers during an access change neither the address nor the strobe width of that access. They take effect from the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_sel | input | 2 | Register select: 0 low, 1 high, 2 page, 3 stretch |
| cfg_wdata | input | 8 | Configuration write data |
| req_valid | input | 1 | Access request, taken only while idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_wdata | input | 8 | Byte to write |
| xm_addr | output | 24 | External memory address |
| xm_wdata | output | 8 | Outgoing data bus |
| xm_rdata | input | 8 | Incoming data bus |
| xm_rd | output | 1 | Read strobe |
| xm_wr | output | 1 | Write strobe |
| xm_drive | output | 1 | Output enable for the outgoing data pads |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte captured by the last read |

## Verification
The assertions assume that the core drives `req_valid` and the configuration port only as synchronous inputs, and that `rst` is held for at least one clock. They also assume that the memory presents valid read data by the final strobe cycle, and not necessarily before it. The bench changes inputs only on falling edges. Its memory model drives a wrong byte on every strobe cycle except the last one, so a design that samples too early returns a wrong byte. The bench also writes to the registers and raises the request while an access is under way, and then checks that none of this leaks into the access in progress.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int XM_DATA_W   = 8;
    localparam int XM_STRETCH_W = 3;
    localparam int XM_PTR_BYTES = 3;

    typedef enum logic [1:0] {
        CFG_PTR_LO  = 2'd0,
        CFG_PTR_HI  = 2'd1,
        CFG_PTR_PG  = 2'd2,
        CFG_STRETCH = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        XS_IDLE   = 2'd0,
        XS_SETUP  = 2'd1,
        XS_STROBE = 2'd2,
        XS_HOLD   = 2'd3
    } xs_state_e;

endpackage

// File: rtl/xmem_ptr_regs.sv
module xmem_ptr_regs
    import xmem_pkg::*;
#(
    parameter int DATA_W    = XM_DATA_W,
    parameter int STRETCH_W = XM_STRETCH_W,
    localparam int ADDR_W   = XM_PTR_BYTES * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [ADDR_W-1:0]    ptr_addr,
    output logic [STRETCH_W-1:0] stretch
);

    typedef struct packed {
        logic [DATA_W-1:0]    lo;
        logic [DATA_W-1:0]    hi;
        logic [DATA_W-1:0]    pg;
        logic [STRETCH_W-1:0] str;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                CFG_PTR_LO:  r_d.lo  = cfg_wdata;
                CFG_PTR_HI:  r_d.hi  = cfg_wdata;
                CFG_PTR_PG:  r_d.pg  = cfg_wdata;
                CFG_STRETCH: r_d.str = cfg_wdata[STRETCH_W-1:0];
                default:     r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ptr_addr = {r_q.pg, r_q.hi, r_q.lo};
    assign stretch  = r_q.str;

    // R2: a pointer write is visible in the next cycle at the matching address byte
    p_lo_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd0) |=> (ptr_addr[DATA_W-1:0] == $past(cfg_wdata)));

    p_pg_write_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd2) |=> (ptr_addr[ADDR_W-1:ADDR_W-DATA_W] == $past(cfg_wdata)));

endmodule

// File: rtl/xmem_access_fsm.sv
module xmem_access_fsm
    import xmem_pkg::*;
#(
    parameter int DATA_W    = XM_DATA_W,
    parameter int STRETCH_W = XM_STRETCH_W,
    localparam int ADDR_W   = XM_PTR_BYTES * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [ADDR_W-1:0]    ptr_addr,
    input  logic [STRETCH_W-1:0] stretch,
    input  logic [DATA_W-1:0]    xm_rdata,
    output logic [ADDR_W-1:0]    xm_addr,
    output logic [DATA_W-1:0]    xm_wdata,
    output logic                 xm_rd,
    output logic                 xm_wr,
    output logic                 xm_drive,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data
);

    localparam logic [STRETCH_W-1:0] CNT_ONE = {{(STRETCH_W-1){1'b0}}, 1'b1};
    localparam logic [STRETCH_W:0]   W_ONE   = {{STRETCH_W{1'b0}}, 1'b1};
    localparam logic [STRETCH_W:0]   W_MAX   = W_ONE << STRETCH_W;

    typedef struct packed {
        xs_state_e            state;
        logic [STRETCH_W-1:0] cnt;
        logic [ADDR_W-1:0]    addr;
        logic [DATA_W-1:0]    wdata;
        logic                 wr;
        logic [DATA_W-1:0]    rdata;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            XS_IDLE: begin
                if (req_valid) begin
                    s_d.state = XS_SETUP;
                    s_d.addr  = ptr_addr;
                    s_d.wdata = req_wdata;
                    s_d.wr    = req_write;
                    s_d.cnt   = stretch;
                end
            end
            XS_SETUP: begin
                s_d.state = XS_STROBE;
            end
            XS_STROBE: begin
                if (s_q.cnt == '0) begin
                    s_d.state = XS_HOLD;
                    if (!s_q.wr) begin
                        s_d.rdata = xm_rdata;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - CNT_ONE;
                end
            end
            XS_HOLD: begin
                s_d.state = XS_IDLE;
            end
            default: s_d.state = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy     = (s_q.state != XS_IDLE);
    assign done     = (s_q.state == XS_HOLD);
    assign xm_rd    = (s_q.state == XS_STROBE) && !s_q.wr;
    assign xm_wr    = (s_q.state == XS_STROBE) &&  s_q.wr;
    assign xm_drive = busy && s_q.wr;
    assign xm_addr  = s_q.addr;
    assign xm_wdata = s_q.wdata;
    assign rd_data  = s_q.rdata;

    // Strobe-width watch counter, used only by the checks below
    logic [STRETCH_W:0] wcnt_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q <= '0;
        end else if (xm_rd || xm_wr) begin
            wcnt_q <= wcnt_q + W_ONE;
        end else begin
            wcnt_q <= '0;
        end
    end

    p_strobes_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(xm_rd && xm_wr));

    p_width_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (xm_rd || xm_wr) |-> (wcnt_q < W_MAX));

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(xm_rd || xm_wr));

    p_no_drive_read_r7: assert property (@(posedge clk) disable iff (rst)
        xm_rd |-> !xm_drive);

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(xm_addr) && $stable(xm_wdata)));

    p_setup_before_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(xm_rd || xm_wr) |-> $past(busy));

    p_busy_drop_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_rdata_held_r5: assert property (@(posedge clk) disable iff (rst)
        (!done && $past(!done)) |-> $stable(rd_data));

endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl
    import xmem_pkg::*;
#(
    parameter int DATA_W    = XM_DATA_W,
    parameter int STRETCH_W = XM_STRETCH_W,
    localparam int ADDR_W   = XM_PTR_BYTES * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] xm_addr,
    output logic [DATA_W-1:0] xm_wdata,
    input  logic [DATA_W-1:0] xm_rdata,
    output logic              xm_rd,
    output logic              xm_wr,
    output logic              xm_drive,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    logic [ADDR_W-1:0]    ptr_addr;
    logic [STRETCH_W-1:0] stretch;

    xmem_ptr_regs #(
        .DATA_W    (DATA_W),
        .STRETCH_W (STRETCH_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .ptr_addr  (ptr_addr),
        .stretch   (stretch)
    );

    xmem_access_fsm #(
        .DATA_W    (DATA_W),
        .STRETCH_W (STRETCH_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .ptr_addr  (ptr_addr),
        .stretch   (stretch),
        .xm_rdata  (xm_rdata),
        .xm_addr   (xm_addr),
        .xm_wdata  (xm_wdata),
        .xm_rd     (xm_rd),
        .xm_wr     (xm_wr),
        .xm_drive  (xm_drive),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data)
    );

    // R1: no bus activity on the first cycle out of reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> (!xm_rd && !xm_wr && !xm_drive && !busy && !done));

    // R6: acceptance only from idle
    p_accept_idle_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

endmodule

// File: tb/xmem_stretch_ctrl_bench.sv
module xmem_stretch_ctrl_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [7:0]  cfg_wdata = 8'd0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_wdata = 8'd0;
    logic [23:0] xm_addr;
    logic [7:0]  xm_wdata;
    logic [7:0]  xm_rdata = 8'd0;
    logic        xm_rd, xm_wr, xm_drive, busy, done;
    logic [7:0]  rd_data;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [7:0] sh_lo = 8'd0, sh_hi = 8'd0, sh_pg = 8'd0;
    logic [2:0] sh_str = 3'd0;
    logic [7:0] last_rd = 8'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_stretch_ctrl u_xmem_stretch_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
        .xm_addr(xm_addr), .xm_wdata(xm_wdata), .xm_rdata(xm_rdata),
        .xm_rd(xm_rd), .xm_wr(xm_wr), .xm_drive(xm_drive),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    function automatic logic [7:0] mem_val(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[20:16], a[23:21]} ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [7:0] val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: sh_lo = val;
            2'd1: sh_hi = val;
            2'd2: sh_pg = val;
            default: sh_str = val[2:0];
        endcase
    endtask

    // Runs one access; starts and ends just after a falling edge.
    task automatic access(input bit wr, input logic [7:0] wd, input bit disturb);
        logic [23:0] ea = {sh_pg, sh_hi, sh_lo};
        int n = int'(sh_str);
        int scount = 0, first = 0, done_cyc = 0;
        bit addr_ok = 1'b1, data_ok = 1'b1, drv_ok = 1'b1, dir_ok = 1'b1, busy_ok = 1'b1;
        logic [7:0] got = 8'd0;
        logic [7:0] new_lo = sh_lo + 8'd1;
        logic [2:0] new_str = ~sh_str;
        req_valid = 1'b1; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 1; cyc <= 20; cyc++) begin
            if (!busy) busy_ok = 1'b0;
            if (xm_addr !== ea) addr_ok = 1'b0;
            if (wr && xm_wdata !== wd) data_ok = 1'b0;
            if (xm_drive !== wr) drv_ok = 1'b0;
            if ((wr && xm_rd) || (!wr && xm_wr) || (xm_rd && xm_wr)) dir_ok = 1'b0;
            if (xm_rd || xm_wr) begin
                scount++;
                if (first == 0) first = cyc;
                xm_rdata = (scount == n + 1) ? mem_val(ea) : ~mem_val(ea);
            end else begin
                xm_rdata = 8'hA5;
            end
            if (done) begin
                done_cyc = cyc;
                got = rd_data;
                break;
            end
            if (disturb && cyc == 1) begin
                cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = {5'd0, new_str};
            end else if (disturb && cyc == 2) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = new_lo; req_valid = 1'b1;
            end else begin
                cfg_we = 1'b0; req_valid = 1'b0;
            end
            @(negedge clk);
        end
        cfg_we = 1'b0; req_valid = 1'b0;
        if (disturb) begin
            sh_str = new_str;
            sh_lo = new_lo;
        end
        check(first == 2, "R4 strobe after one setup cycle", first, 2);
        check(scount == n + 1, wr ? "R3 write strobe width" : "R3 read strobe width", scount, n + 1);
        check(done_cyc == n + 3, "R5 done cycle after strobe", done_cyc, n + 3);
        check(addr_ok, disturb ? "R9 address unaffected by mid-access writes" : "R2 address from pointers",
              int'(xm_addr), int'(ea));
        check(data_ok && addr_ok, "R4 address/data stable through access", int'(xm_wdata), int'(wd));
        check(drv_ok, "R7 drive enable matches direction", int'(xm_drive), int'(wr));
        check(dir_ok, "R8 only matching strobe", int'({xm_rd, xm_wr}), 0);
        check(busy_ok, "R6 busy through access", 0, 1);
        if (!wr) begin
            check(got == mem_val(ea), "R5 read data sampled on final strobe cycle", int'(got), int'(mem_val(ea)));
            last_rd = mem_val(ea);
        end
        @(negedge clk);
        check(!busy && !done, "R6 busy and done drop after done cycle", int'({busy, done}), 0);
        check(rd_data == last_rd, "R5 read data held", int'(rd_data), int'(last_rd));
        if (disturb) begin
            @(negedge clk);
            check(!busy && !xm_rd && !xm_wr, "R6 request during busy ignored", int'({busy, xm_rd, xm_wr}), 0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) begin
            @(negedge clk);
            check(!xm_rd && !xm_wr && !xm_drive && !busy && !done, "R1 idle in reset",
                  int'({xm_rd, xm_wr, xm_drive, busy, done}), 0);
        end
        rst = 1'b0;
        @(negedge clk);
        check(!xm_rd && !xm_wr && !xm_drive && !busy && !done, "R1 idle after reset",
              int'({xm_rd, xm_wr, xm_drive, busy, done}), 0);

        // Directed: every stretch value, both directions; upper cfg bits set to test R3 masking
        for (int s = 0; s < 8; s++) begin
            cfg_write(2'd3, 8'hF8 | 8'(s));
            cfg_write(2'd0, 8'(s * 17));
            cfg_write(2'd1, 8'(8'hC0 ^ s));
            cfg_write(2'd2, 8'(s * 29 + 3));
            access(1'b0, 8'h00, 1'b0);
            access(1'b1, 8'(8'h5A + s), 1'b0);
        end

        // Corner: page swap only (R2) with extreme pointer values
        cfg_write(2'd3, 8'd0);
        cfg_write(2'd0, 8'hFF);
        cfg_write(2'd1, 8'hFF);
        cfg_write(2'd2, 8'hFF);
        access(1'b0, 8'h00, 1'b0);
        cfg_write(2'd2, 8'h00);
        access(1'b0, 8'h00, 1'b0);

        // Corner: mid-access disturbance (R9, R6)
        cfg_write(2'd3, 8'd5);
        access(1'b0, 8'h00, 1'b1);
        access(1'b1, 8'h99, 1'b1);
        access(1'b0, 8'h00, 1'b0);

        // Random mix
        for (int i = 0; i < 60; i++) begin
            cfg_write(2'($urandom_range(0, 3)), 8'($urandom));
            access(1'($urandom_range(0, 1)), 8'($urandom), ($urandom_range(0, 7) == 0));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule